// File: doc/BRIEF.md
# Debounced Cell Fault Aggregator

This block collects the fault indications of one monitoring stage in a stacked battery string and turns them into a single active-high fault line. Its inputs are an overvoltage bit and an undervoltage bit for each cell, one overtemperature bit, and the fault line of the stage above. Before a cell or temperature indication can reach the output, it must stay present for a programmable number of ticks of a slow timebase. The fault line from the stage above is already qualified upstream, so it is ORed in directly.

Three things decide which sources take part. A two-bit cell-count setting decides which cells are populated. A runtime pin switches undervoltage detection on or off. A defect mask from self-diagnosis suppresses individual comparators and the chain link. Reporting happens only while the stage is powered and its self-diagnosis has passed. Every source is a plain level input. There is no data stream and no back-pressure at the edge of the block.

Top module: `cell_fault_aggregator`

## Requirements
- R1: After reset, fault_out and cfg_err are 0.
- R2: An enabled cell overvoltage bit held continuously drives fault_out high only once it has been present across DEB_TICKS tick pulses; after DEB_TICKS-1 ticks fault_out is still 0.
- R3: If a source drops for even one clock, its tick count restarts from zero.
- R4: fault_out returns to 0 within two clocks after the last qualified source and the chain input go away.
- R5: With uv_en = 0 the undervoltage bits have no effect. With uv_en = 1 they are debounced like the overvoltage bits.
- R6: cfg_sel selects the populated cells: 2'b00 gives cells 0..3 (bits 4 and 5 ignored), 2'b01 gives cells 0..4 (bit 5 ignored), 2'b11 gives all six cells.
- R7: cfg_sel = 2'b10 is handled as six-cell operation and sets cfg_err to 1 one clock later. cfg_err is 0 one clock after any other setting.
- R8: ot_raw = 1 (the over-temperature state, which includes an open sensor input) is debounced for DEB_TICKS ticks in the same way as a cell source.
- R9: A source whose defect bit (ov_bad, uv_bad, ot_bad) is set is ignored, and the remaining sources still raise fault_out.
- R10: chain_in = 1 with chain_bad = 0 sets fault_out one clock later, without debounce. With chain_bad = 1, chain_in is ignored.
- R11: While diag_pass = 0, fault_out is 0 and all tick counts are held at zero.
- R12: While pwr_on = 0, fault_out is 0 and all tick counts are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe of the slow debounce timebase |
| pwr_on | input | 1 | 1 = stage powered, 0 = power-down |
| diag_pass | input | 1 | 1 once self-diagnosis has passed |
| cfg_sel | input | 2 | Cell-count selection |
| uv_en | input | 1 | Undervoltage detection enable |
| ov_raw | input | NCELL | Per-cell overvoltage comparator bits |
| uv_raw | input | NCELL | Per-cell undervoltage comparator bits |
| ot_raw | input | 1 | Overtemperature comparator bit |
| chain_in | input | 1 | Fault line from the stage above |
| ov_bad | input | NCELL | Defect mask for the overvoltage comparators |
| uv_bad | input | NCELL | Defect mask for the undervoltage comparators |
| ot_bad | input | 1 | Defect flag for the overtemperature comparator |
| chain_bad | input | 1 | Defect flag for the chain link |
| fault_out | output | 1 | Aggregated active-high fault |
| cfg_err | output | 1 | Reserved cell-count setting in use |

## Verification
One group of stimuli holds a single source across exactly DEB_TICKS-1 and DEB_TICKS ticks. A second drops the source for one clock just short of the threshold. Together they separate a correct continuous-persistence count from an off-by-one count and from a count that does not restart.

Other stimuli place faults on unpopulated cells under each cell-count code, on undervoltage bits with the enable low, and on sources marked defective. Each of these is paired with a fault on an allowed source, so a mask that is too wide shows up as well as one that is too narrow.

The chain input is driven with and without its defect flag. The gating controls are released while sources stay active, which shows that the counts were held at zero rather than kept.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  typedef enum logic [1:0] {
    CFG_FOUR = 2'b00,
    CFG_FIVE = 2'b01,
    CFG_RSVD = 2'b10,
    CFG_SIX  = 2'b11
  } cell_cfg_e;

  // number of populated cells for a setting, given the full width
  function automatic int unsigned cells_for(cell_cfg_e c, int unsigned full);
    case (c)
      CFG_FOUR: cells_for = full - 2;
      CFG_FIVE: cells_for = full - 1;
      default:  cells_for = full;
    endcase
  endfunction
endpackage

// File: rtl/cfa_cell_decode.sv
module cfa_cell_decode
  import cfa_pkg::*;
#(
  parameter int unsigned NCELL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_sel,
  output logic [NCELL-1:0] cell_en,
  output logic             cfg_err
);
  cell_cfg_e   cfg;
  int unsigned ncells;

  assign cfg    = cell_cfg_e'(cfg_sel);
  assign ncells = cells_for(cfg, NCELL);

  for (genvar i = 0; i < NCELL; i++) begin : g_en
    assign cell_en[i] = (i < ncells);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= (cfg == CFG_RSVD);
  end
endmodule

// File: rtl/cfa_debounce.sv
module cfa_debounce #(
  parameter int unsigned DEB_TICKS = 200,
  localparam int unsigned CW = $clog2(DEB_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  output logic qual
);
  localparam logic [CW-1:0] LIMIT = CW'(DEB_TICKS);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!active)             cnt <= '0;
    else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign qual = active && (cnt == LIMIT);
endmodule

// File: rtl/cell_fault_aggregator.sv
module cell_fault_aggregator #(
  parameter int unsigned NCELL     = 6,
  parameter int unsigned DEB_TICKS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwr_on,
  input  logic             diag_pass,
  input  logic [1:0]       cfg_sel,
  input  logic             uv_en,
  input  logic [NCELL-1:0] ov_raw,
  input  logic [NCELL-1:0] uv_raw,
  input  logic             ot_raw,
  input  logic             chain_in,
  input  logic [NCELL-1:0] ov_bad,
  input  logic [NCELL-1:0] uv_bad,
  input  logic             ot_bad,
  input  logic             chain_bad,
  output logic             fault_out,
  output logic             cfg_err
);
  localparam int unsigned NSRC = 2 * NCELL + 1;

  logic [NCELL-1:0] cell_en;
  logic [NSRC-1:0]  src_raw, src_ok, src_qual;
  logic             live, chain_ok;

  cfa_cell_decode #(.NCELL(NCELL)) u_decode (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
    .cell_en(cell_en), .cfg_err(cfg_err)
  );

  assign live = pwr_on && diag_pass;

  // source order: overvoltage cells, undervoltage cells, temperature
  assign src_raw = {ot_raw, uv_raw, ov_raw};
  assign src_ok  = {~ot_bad,
                    cell_en & ~uv_bad & {NCELL{uv_en}},
                    cell_en & ~ov_bad};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    cfa_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .active(live && src_raw[s] && src_ok[s]),
      .qual(src_qual[s])
    );
  end

  assign chain_ok = chain_in && !chain_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_out <= 1'b0;
    else        fault_out <= live && ((|src_qual) || chain_ok);
  end
endmodule

// File: rtl/cell_fault_aggregator_chk.sv
module cell_fault_aggregator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       pwr_on,
  input logic       diag_pass,
  input logic [1:0] cfg_sel,
  input logic       chain_in,
  input logic       chain_bad,
  input logic       fault_out,
  input logic       cfg_err
);
  // R10
  chain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && diag_pass && chain_in && !chain_bad) |=> fault_out);

  // R11
  no_fault_undiag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_pass |=> !fault_out);

  // R12
  pwr_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !fault_out);

  // R7
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'b10) |=> cfg_err);

  // R7
  legal_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel != 2'b10) |=> !cfg_err);

  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_out) && !($past(chain_in) && !$past(chain_bad))) |-> $past(tick, 2));
endmodule

bind cell_fault_aggregator cell_fault_aggregator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_on(pwr_on),
  .diag_pass(diag_pass), .cfg_sel(cfg_sel), .chain_in(chain_in),
  .chain_bad(chain_bad), .fault_out(fault_out), .cfg_err(cfg_err)
);

// File: tb/cell_fault_aggregator_bench.sv
module cell_fault_aggregator_bench;
  localparam int unsigned NC  = 6;
  localparam int unsigned DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, pwr_on = 1'b0, diag_pass = 1'b0, uv_en = 1'b1;
  logic [1:0] cfg_sel = 2'b11;
  logic [NC-1:0] ov_raw = '0, uv_raw = '0, ov_bad = '0, uv_bad = '0;
  logic ot_raw = 1'b0, chain_in = 1'b0, ot_bad = 1'b0, chain_bad = 1'b0;
  logic fault_out, cfg_err;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic  f;
    logic  e;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  cell_fault_aggregator #(.NCELL(NC), .DEB_TICKS(DEB)) u_cell_fault_aggregator (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_on(pwr_on), .diag_pass(diag_pass),
    .cfg_sel(cfg_sel), .uv_en(uv_en), .ov_raw(ov_raw), .uv_raw(uv_raw),
    .ot_raw(ot_raw), .chain_in(chain_in), .ov_bad(ov_bad), .uv_bad(uv_bad),
    .ot_bad(ot_bad), .chain_bad(chain_bad), .fault_out(fault_out), .cfg_err(cfg_err)
  );

  // monitor: compares one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        total++;
        if (fault_out !== it.f || cfg_err !== it.e) begin
          bad++;
          $display("FAIL %s: fault_out=%b cfg_err=%b expected fault_out=%b cfg_err=%b",
                   it.tag, fault_out, cfg_err, it.f, it.e);
        end
      end
    end
  end

  task automatic expect_out(input logic f, input logic e, input string tag);
    exp_t it;
    @(posedge clk);
    it.f = f; it.e = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    ov_raw = '0; uv_raw = '0; ot_raw = 1'b0; chain_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out(1'b0, 1'b0, "R1 reset");
    pwr_on = 1'b1; diag_pass = 1'b1;

    // R2 exact threshold
    @(negedge clk) ov_raw[0] = 1'b1;
    ticks(DEB - 1);
    expect_out(1'b0, 1'b0, "R2 before threshold");
    ticks(1);
    expect_out(1'b1, 1'b0, "R2 at threshold");
    // R4 release
    @(negedge clk) ov_raw[0] = 1'b0;
    @(negedge clk);
    expect_out(1'b0, 1'b0, "R4 release");

    // R3 restart after a one-clock drop
    @(negedge clk) ov_raw[2] = 1'b1;
    ticks(DEB - 1);
    @(negedge clk) ov_raw[2] = 1'b0;
    @(negedge clk) ov_raw[2] = 1'b1;
    ticks(DEB - 1);
    expect_out(1'b0, 1'b0, "R3 restarted count");
    ticks(1);
    expect_out(1'b1, 1'b0, "R3 full count");
    clear_all();

    // R5 undervoltage enable
    uv_en = 1'b0;
    @(negedge clk) uv_raw[1] = 1'b1;
    ticks(DEB + 2);
    expect_out(1'b0, 1'b0, "R5 uv disabled");
    uv_en = 1'b1;
    ticks(DEB);
    expect_out(1'b1, 1'b0, "R5 uv enabled");
    clear_all();

    // R6 four cells
    cfg_sel = 2'b00;
    @(negedge clk) begin ov_raw[5] = 1'b1; uv_raw[4] = 1'b1; end
    ticks(DEB + 2);
    expect_out(1'b0, 1'b0, "R6 four-cell masks cells 4,5");
    ov_raw[3] = 1'b1;
    ticks(DEB);
    expect_out(1'b1, 1'b0, "R6 four-cell keeps cell 3");
    clear_all();
    // R6 five cells
    cfg_sel = 2'b01;
    @(negedge clk) ov_raw[5] = 1'b1;
    ticks(DEB + 2);
    expect_out(1'b0, 1'b0, "R6 five-cell masks cell 5");
    ov_raw[4] = 1'b1;
    ticks(DEB);
    expect_out(1'b1, 1'b0, "R6 five-cell keeps cell 4");
    clear_all();

    // R7 reserved setting
    cfg_sel = 2'b10;
    expect_out(1'b0, 1'b1, "R7 flag set");
    ov_raw[5] = 1'b1;
    ticks(DEB);
    expect_out(1'b1, 1'b1, "R7 six cells active");
    clear_all();
    cfg_sel = 2'b11;
    expect_out(1'b0, 1'b0, "R7 flag clears");

    // R8 temperature
    @(negedge clk) ot_raw = 1'b1;
    ticks(DEB - 1);
    expect_out(1'b0, 1'b0, "R8 before threshold");
    ticks(1);
    expect_out(1'b1, 1'b0, "R8 at threshold");
    clear_all();

    // R9 defect mask
    ov_bad[0] = 1'b1;
    @(negedge clk) ov_raw[0] = 1'b1;
    ticks(DEB + 2);
    expect_out(1'b0, 1'b0, "R9 defective source ignored");
    ot_raw = 1'b1;
    ticks(DEB);
    expect_out(1'b1, 1'b0, "R9 good source still reported");
    clear_all();
    ov_bad = '0;

    // R10 chain
    @(negedge clk) chain_in = 1'b1;
    expect_out(1'b1, 1'b0, "R10 chain passes");
    chain_bad = 1'b1;
    expect_out(1'b0, 1'b0, "R10 broken chain ignored");
    clear_all();
    chain_bad = 1'b0;

    // R11 diagnosis gate
    diag_pass = 1'b0;
    @(negedge clk) ov_raw[1] = 1'b1;
    ticks(DEB + 2);
    expect_out(1'b0, 1'b0, "R11 blocked before pass");
    diag_pass = 1'b1;
    ticks(DEB - 1);
    expect_out(1'b0, 1'b0, "R11 count held at zero");
    ticks(1);
    expect_out(1'b1, 1'b0, "R11 reports after pass");

    // R12 power-down
    pwr_on = 1'b0;
    expect_out(1'b0, 1'b0, "R12 power-down forces low");
    ticks(2);
    pwr_on = 1'b1;
    ticks(DEB - 1);
    expect_out(1'b0, 1'b0, "R12 count cleared");
    clear_all();

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule